// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block recovers bytes from an asynchronous serial line. It oversamples the line on a baud tick supplied from outside. The frame format is a low start bit, 7 or 8 data bits sent least significant bit first, an optional parity bit and one or more high stop bits. A completed byte goes into a one-entry receive buffer, and a receive-complete pulse is raised for one clock.

Three sticky error flags sit in a read-only 8-bit status register: a parity mismatch, a stop bit that reads low, and a byte that arrives while the buffer still holds an unread one. To recover, software reads the status register, which clears the flags, and then reads the buffer, which frees it. When either enable input drops, the receiver stops the frame in progress and clears the flags.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `status_q` and `rxbuf_q` are 0. The status layout is bit 2 = parity error, bit 1 = framing error, bit 0 = overrun. Bits 7..3 always read 0.
- R2: While `pwr_en` or `rx_en` is low, the flags and the buffer-full state are cleared at the next clock edge and any frame in progress is dropped. The buffer contents are kept.
- R3: A cycle with `stat_rd` high clears all three flags. If a completion in that same cycle raises a flag, that flag ends up set.
- R4: `parity_mode` 00 = no parity bit, 01 = parity bit present and ignored, 10 = even, 11 = odd. The parity error flag is set only in modes 10 and 11, when the received parity bit does not match the data.
- R5: Only the first stop bit is sampled. If it reads 0, the framing error flag is set, and the byte is still delivered.
- R6: If a frame completes while the buffer is full and is not being read in that cycle, the overrun flag is set, the new byte is dropped, `rxbuf_q` is unchanged and no `rx_done` pulse is raised.
- R7: `buf_rd` frees the buffer. A `buf_rd` in the same cycle as a completion lets the new byte in with no overrun.
- R8: Sampling runs at 16 baud ticks per bit. A start is detected on a tick that sees the line low and is confirmed on the 8th tick after that. If the line is high at confirmation, the receiver returns to idle with no effect on any output.
- R9: `short_data` = 1 selects 7 data bits, and `rxbuf_q[7]` then reads 0. Otherwise 8 data bits are received. Bits arrive least significant bit first.
- R10: A stored byte produces exactly one single-cycle `rx_done` pulse. The pulse comes one clock after the edge that samples the first stop bit, in the same cycle as the buffer and flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Block power enable |
| rx_en | input | 1 | Receive enable |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line |
| parity_mode | input | 2 | Parity setting (see R4) |
| short_data | input | 1 | 1 = 7 data bits, 0 = 8 |
| stat_rd | input | 1 | Status register read strobe |
| buf_rd | input | 1 | Receive buffer read strobe |
| status_q | output | 8 | Error status register |
| rxbuf_q | output | 8 | Receive buffer register |
| rx_done | output | 1 | Receive-complete pulse |

## Verification
Two pairs of events can land in the same cycle as a frame completion. One pair is a buffer read with a completion, which decides between storing the byte and an overrun. The other is a status read with a completion that carries an error, which decides whether the new flag survives the clear. The bench waits until its own reference model has a completion pending, then raises `buf_rd` or `stat_rd` for exactly the cycle in which the design commits the frame. It judges the result against the reference model on every clock, and again with explicit checks that the byte was stored without overrun and that the framing flag stayed set.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_SKIP = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_PAR,
        FS_STOP
    } frm_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } frame_res_t;

    typedef struct packed {
        logic pe;
        logic fe;
        logic ove;
    } err_flags_t;

    // Mismatch only when parity is checked (mode bit 1 set); bit 0 selects odd.
    function automatic logic par_fail(logic [BYTE_W-1:0] d, logic pbit, par_mode_e mode);
        return mode[1] & (^d ^ pbit ^ mode[0]);
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd,
    input  par_mode_e  par_mode,
    input  logic       short_data,
    output logic       frm_done,
    output frame_res_t frm_res
);

    localparam int unsigned CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
    localparam int unsigned IDX_W = $clog2(BYTE_W);

    frm_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] sh;
    logic              pbit;
    logic [IDX_W-1:0]  last_idx;
    logic [BYTE_W-1:0] assembled;

    assign last_idx  = short_data ? IDX_W'(BYTE_W - 2) : IDX_W'(BYTE_W - 1);
    assign assembled = short_data ? {1'b0, sh[BYTE_W-1:1]} : sh;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st       <= FS_IDLE;
            cnt      <= '0;
            idx      <= '0;
            sh       <= '0;
            pbit     <= 1'b0;
            frm_done <= 1'b0;
            frm_res  <= '0;
        end else begin
            frm_done <= 1'b0;
            if (tick) begin
                case (st)
                    FS_IDLE: begin
                        if (!rxd) begin
                            st  <= FS_START;
                            cnt <= '0;
                        end
                    end
                    FS_START: begin
                        if (cnt == HALF) begin
                            cnt <= '0;
                            idx <= '0;
                            st  <= rxd ? FS_IDLE : FS_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_DATA: begin
                        if (cnt == LAST) begin
                            cnt <= '0;
                            sh  <= {rxd, sh[BYTE_W-1:1]};
                            idx <= idx + 1'b1;
                            if (idx == last_idx)
                                st <= (par_mode == PAR_NONE) ? FS_STOP : FS_PAR;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_PAR: begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            pbit <= rxd;
                            st   <= FS_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_STOP: begin
                        if (cnt == LAST) begin
                            cnt              <= '0;
                            st               <= FS_IDLE;
                            frm_done         <= 1'b1;
                            frm_res.data     <= assembled;
                            frm_res.par_err  <= par_fail(assembled, pbit, par_mode);
                            frm_res.frm_err  <= !rxd;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= FS_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              frm_done,
    input  frame_res_t        frm_res,
    input  logic              stat_rd,
    input  logic              buf_rd,
    output err_flags_t        flags,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              buf_full,
    output logic              rx_done
);

    logic still_full;
    logic accept;

    // A read in the same cycle frees the slot before the new byte is judged.
    assign still_full = buf_full & ~buf_rd;
    assign accept     = frm_done & ~still_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            rx_byte  <= '0;
            buf_full <= 1'b0;
            rx_done  <= 1'b0;
        end else if (!en) begin
            flags    <= '0;
            buf_full <= 1'b0;
            rx_done  <= 1'b0;
        end else begin
            rx_done   <= accept;
            buf_full  <= frm_done | still_full;
            if (accept)
                rx_byte <= frm_res.data;
            flags.ove <= (flags.ove & ~stat_rd) | (frm_done & still_full);
            flags.pe  <= (flags.pe  & ~stat_rd) | (frm_done & frm_res.par_err);
            flags.fe  <= (flags.fe  & ~stat_rd) | (frm_done & frm_res.frm_err);
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_en,
    input  logic       rx_en,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic [1:0] parity_mode,
    input  logic       short_data,
    input  logic       stat_rd,
    input  logic       buf_rd,
    output logic [7:0] status_q,
    output logic [7:0] rxbuf_q,
    output logic       rx_done
);

    logic       en;
    logic       frm_done;
    frame_res_t frm_res;
    err_flags_t flags;
    logic       buf_full;

    assign en = pwr_en & rx_en;

    uart_rx_frame #(.OSR(OSR)) i_frame (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tick       (baud_tick),
        .rxd        (rxd),
        .par_mode   (par_mode_e'(parity_mode)),
        .short_data (short_data),
        .frm_done   (frm_done),
        .frm_res    (frm_res)
    );

    uart_rx_store i_store (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .frm_done (frm_done),
        .frm_res  (frm_res),
        .stat_rd  (stat_rd),
        .buf_rd   (buf_rd),
        .flags    (flags),
        .rx_byte  (rxbuf_q),
        .buf_full (buf_full),
        .rx_done  (rx_done)
    );

    assign status_q = {5'b00000, flags.pe, flags.fe, flags.ove};

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker (
    input logic       clk,
    input logic       rst,
    input logic       pwr_en,
    input logic       rx_en,
    input logic       stat_rd,
    input logic       buf_rd,
    input logic [1:0] parity_mode,
    input logic       short_data,
    input logic [7:0] status_q,
    input logic [7:0] rxbuf_q,
    input logic       rx_done,
    input logic       frm_done,
    input logic       buf_full
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (status_q == 8'h00 && !rx_done));

    assert_off_clears_R2: assert property (@(posedge clk) disable iff (rst)
        !(pwr_en && rx_en) |=> (status_q[2:0] == 3'b000 && !rx_done));

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !frm_done && pwr_en && rx_en) |=> (status_q[2:0] == 3'b000));

    assert_pe_checked_mode_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[2]) |-> $past(parity_mode[1]));

    assert_overrun_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_done && buf_full && !buf_rd && pwr_en && rx_en)
            |=> (status_q[0] && $stable(rxbuf_q) && !rx_done));

    assert_read_accepts_R7: assert property (@(posedge clk) disable iff (rst)
        (frm_done && buf_full && buf_rd && pwr_en && rx_en) |=> rx_done);

    assert_short_msb_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && short_data) |-> !rxbuf_q[7]);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);

endmodule

bind uart_rx_status uart_rx_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_en      (pwr_en),
    .rx_en       (rx_en),
    .stat_rd     (stat_rd),
    .buf_rd      (buf_rd),
    .parity_mode (parity_mode),
    .short_data  (short_data),
    .status_q    (status_q),
    .rxbuf_q     (rxbuf_q),
    .rx_done     (rx_done),
    .frm_done    (frm_done),
    .buf_full    (buf_full)
);

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;

    logic       clk = 1'b0;
    logic       rst;
    logic       pwr_en, rx_en, baud_tick, rxd;
    logic [1:0] parity_mode;
    logic       short_data, stat_rd, buf_rd;
    logic [7:0] status_q, rxbuf_q;
    logic       rx_done;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    done_cnt = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    uart_rx_status i_uart_rx_status (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .rx_en(rx_en),
        .baud_tick(baud_tick), .rxd(rxd), .parity_mode(parity_mode),
        .short_data(short_data), .stat_rd(stat_rd), .buf_rd(buf_rd),
        .status_q(status_q), .rxbuf_q(rxbuf_q), .rx_done(rx_done)
    );

    // Baud tick: one cycle in four, so one bit lasts 64 clocks.
    initial begin
        baud_tick = 1'b0;
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    // Reference model, counted in ticks since the start was seen.
    bit         m_act, m_pv, m_ppe, m_pfe;
    int         m_t;
    logic [7:0] m_sh, m_pd;
    logic       m_pb;
    bit         e_pe, e_fe, e_ove, e_full, e_done;
    logic [7:0] e_buf;

    always @(posedge clk) begin
        bit en, fullr;
        int idx, nb, stop_idx;
        en = pwr_en && rx_en;
        if (rst || !en) begin
            m_act = 0; m_pv = 0; m_t = 0;
            e_pe = 0; e_fe = 0; e_ove = 0; e_full = 0; e_done = 0;
            if (rst) e_buf = 8'h00;
        end else begin
            fullr  = e_full && !buf_rd;
            e_done = m_pv && !fullr;
            if (stat_rd) begin e_pe = 0; e_fe = 0; e_ove = 0; end
            if (m_pv) begin
                if (fullr) e_ove = 1; else e_buf = m_pd;
                if (m_ppe) e_pe = 1;
                if (m_pfe) e_fe = 1;
            end
            e_full = m_pv || fullr;
            m_pv = 0;
            if (baud_tick) begin
                if (!m_act) begin
                    if (!rxd) begin m_act = 1; m_t = 0; end
                end else begin
                    m_t++;
                    if (m_t >= 8 && (m_t - 8) % 16 == 0) begin
                        idx      = (m_t - 8) / 16;
                        nb       = short_data ? 7 : 8;
                        stop_idx = nb + 1 + ((parity_mode != 2'b00) ? 1 : 0);
                        if (idx == 0) begin
                            if (rxd) m_act = 0;
                            m_sh = 8'h00;
                        end else if (idx <= nb) begin
                            m_sh[idx-1] = rxd;
                        end else if (idx < stop_idx) begin
                            m_pb = rxd;
                        end else begin
                            m_pv  = 1;
                            m_pd  = m_sh;
                            m_ppe = parity_mode[1] && (^m_sh ^ m_pb ^ parity_mode[0]);
                            m_pfe = !rxd;
                            m_act = 0;
                        end
                    end
                end
            end
        end
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (!rst) begin
            n_tests++;
            if (status_q !== {5'b0, e_pe, e_fe, e_ove} || rxbuf_q !== e_buf || rx_done !== e_done) begin
                n_fail++;
                $display("FAIL %s model: status=%h buf=%h done=%b expected status=%h buf=%h done=%b",
                         phase, status_q, rxbuf_q, rx_done, {5'b0, e_pe, e_fe, e_ove}, e_buf, e_done);
            end
            if (rx_done === 1'b1) done_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int clocks);
        rxd = v;
        repeat (clocks) @(negedge clk);
    endtask

    // One frame; parity bit computed here, optionally inverted.
    task automatic send(input logic [7:0] d, input int nb, input bit with_par,
                        input bit odd, input bit flip, input bit stop_ok);
        logic p;
        p = (nb == 7) ? ^d[6:0] : ^d;
        if (odd) p = ~p;
        if (flip) p = ~p;
        hold(1'b0, 64);
        for (int i = 0; i < nb; i++) hold(d[i], 64);
        if (with_par) hold(p, 64);
        if (stop_ok) hold(1'b1, 64);
        else begin hold(1'b0, 40); hold(1'b1, 24); end
        hold(1'b1, 64);
    endtask

    task automatic pulse_stat();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic pulse_buf();
        buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c0;
        rst = 1'b1; pwr_en = 1'b1; rx_en = 1'b1; rxd = 1'b1;
        parity_mode = 2'b00; short_data = 1'b0; stat_rd = 1'b0; buf_rd = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        phase = "R1";
        chk("R1 status after reset", status_q, 8'h00);
        chk("R1 buffer after reset", rxbuf_q, 8'h00);

        phase = "R9";
        c0 = done_cnt;
        send(8'hA5, 8, 0, 0, 0, 1);
        chk("R9 8-bit byte", rxbuf_q, 8'hA5);
        chk("R10 one pulse per byte", done_cnt - c0, 1);
        pulse_buf();

        phase = "R8";
        c0 = done_cnt;
        hold(1'b0, 20); hold(1'b1, 200);
        chk("R8 false start leaves buffer", rxbuf_q, 8'hA5);
        chk("R8 false start no pulse", done_cnt - c0, 0);

        phase = "R4";
        parity_mode = 2'b10;
        send(8'h3C, 8, 1, 0, 0, 1);
        chk("R4 even good", status_q, 8'h00);
        pulse_buf();
        send(8'h3D, 8, 1, 0, 1, 1);
        chk("R4 even bad", status_q, 8'h04);
        phase = "R3";
        pulse_stat();
        chk("R3 read clears", status_q, 8'h00);
        pulse_buf();
        phase = "R4";
        parity_mode = 2'b11;
        send(8'h81, 8, 1, 1, 1, 1);
        chk("R4 odd bad", status_q, 8'h04);
        pulse_stat(); pulse_buf();
        send(8'h7E, 8, 1, 1, 0, 1);
        chk("R4 odd good", status_q, 8'h00);
        pulse_buf();
        parity_mode = 2'b01;
        send(8'h66, 8, 1, 0, 1, 1);
        chk("R4 unchecked parity", status_q, 8'h00);
        chk("R4 unchecked byte", rxbuf_q, 8'h66);
        pulse_buf();

        phase = "R5";
        parity_mode = 2'b00;
        send(8'h5A, 8, 0, 0, 0, 0);
        chk("R5 framing flag", status_q, 8'h02);
        chk("R5 byte kept", rxbuf_q, 8'h5A);
        pulse_stat(); pulse_buf();

        phase = "R6";
        send(8'h11, 8, 0, 0, 0, 1);
        c0 = done_cnt;
        send(8'h22, 8, 0, 0, 0, 1);
        chk("R6 overrun flag", status_q, 8'h01);
        chk("R6 old byte kept", rxbuf_q, 8'h11);
        chk("R6 no pulse", done_cnt - c0, 0);
        pulse_stat(); pulse_buf();
        send(8'h33, 8, 0, 0, 0, 1);
        chk("R6 recovery", rxbuf_q, 8'h33);

        phase = "R7";
        fork
            send(8'h55, 8, 0, 0, 0, 1);
            begin
                do @(negedge clk); while (!m_pv);
                buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0;
            end
        join
        chk("R7 same-cycle read byte", rxbuf_q, 8'h55);
        chk("R7 same-cycle read no overrun", status_q, 8'h00);
        pulse_buf();

        phase = "R3";
        fork
            send(8'h0F, 8, 0, 0, 0, 0);
            begin
                do @(negedge clk); while (!m_pv);
                stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
            end
        join
        chk("R3 new flag survives read", status_q, 8'h02);
        pulse_stat(); pulse_buf();

        phase = "R9";
        short_data = 1'b1;
        send(8'hD3, 7, 0, 0, 0, 1);
        chk("R9 7-bit byte", rxbuf_q, 8'h53);
        pulse_buf();
        parity_mode = 2'b10;
        send(8'hFF, 7, 1, 0, 1, 1);
        chk("R9 7-bit parity byte", rxbuf_q, 8'h7F);
        chk("R9 7-bit parity flag", status_q, 8'h04);
        pulse_stat(); pulse_buf();
        short_data = 1'b0; parity_mode = 2'b00;

        phase = "R2";
        send(8'h99, 8, 0, 0, 0, 0);
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 flags cleared", status_q, 8'h00);
        chk("R2 buffer kept", rxbuf_q, 8'h99);
        rx_en = 1'b1;
        c0 = done_cnt;
        fork
            send(8'hC3, 8, 0, 0, 0, 1);
            begin
                repeat (300) @(negedge clk);
                pwr_en = 1'b0;
            end
        join
        pwr_en = 1'b1;
        repeat (10) @(negedge clk);
        chk("R2 aborted frame no pulse", done_cnt - c0, 0);
        chk("R2 aborted frame buffer", rxbuf_q, 8'h99);
        send(8'h24, 8, 0, 0, 0, 1);
        chk("R2 buffer free after disable", rxbuf_q, 8'h24);

        finish_run();
    end

endmodule